// File: doc/BRIEF.md
# Address-Encoded NAND Command Sequencer

This block sits behind a simple memory-mapped access port and turns each bus access into a sequence of byte cycles on an 8-bit NAND flash bus. Software does not write command registers. The bus address of the access carries the whole operation: the phase, both command opcodes, how many address bytes follow, whether a closing command is issued, whether chip select is released afterwards, and whether the access is the last one of an error-code run. The write data carries the address bytes in a command-phase access, and the payload in a data-phase write.

A command-phase access sends the opening opcode with the command latch raised. It then sends up to four address bytes from the write data with the address latch raised, taking the lowest byte first. If the closing opcode is flagged, it follows the address bytes. When more than four address bytes are asked for, the first access sends four of them. The next command-phase access sends the rest, with no opening opcode, and ends with the closing opcode held over from the first access. A data-phase access moves four bytes on the bus, lowest byte first: strobe-driven writes when the bus access is a write, and strobe-driven reads assembled into the read data when it is a read. It can append the closing opcode, release chip select, or raise a one-cycle error-code-final marker. Each strobe is held low for a fixed number of clock cycles set by a parameter, and is then held high for the same count.

Top module: `nand_cmd_decoder`

## Requirements
- R1: After reset, chip enable is high (inactive), both strobes are high, both latch enables are low, the I/O driver is off and `bus_ready` is high.
- R2: A command-phase access (address bit 19 = 0) starts with one byte cycle with the command latch high, carrying the opcode from address bits [10:3].
- R3: Address bits [23:21] of a command-phase access give the address byte count, 0 to 7. Each address byte is a cycle with the address latch high, taken from the write data lowest byte first. A count of 0 sends the opcode alone.
- R4: When address bit 20 is set, a closing command cycle carrying address bits [18:11] follows the address bytes, or follows the data bytes in a data-phase access. When bit 20 is clear, no closing command is sent.
- R5: A count above 4 sends four address bytes on the first access. The next command-phase access sends the remaining count from its write data, lowest byte first, with no opening opcode. It then sends the held closing opcode if that was flagged.
- R6: A data-phase write (bit 19 = 1, `bus_write` = 1) drives four write-strobe cycles with both latches low, carrying the write data lowest byte first.
- R7: A data-phase read drives four read-strobe cycles with the I/O driver off. The byte read first lands in `bus_rdata[7:0]`, and the result is valid while `bus_done` is high.
- R8: Chip enable goes low when an access is accepted. It stays low across accesses, including command-phase accesses whose bit 21 is set as part of the count. It goes high only in the cycle after the completion of a data-phase access with bit 21 set.
- R9: `ecc_last` pulses for one cycle together with `bus_done` at the end of a data-phase access with address bit 10 set, and never otherwise.
- R10: Every write or read strobe stays low for exactly STROBE_CYC clock cycles. `bus_ready` is low while a sequence runs, and `bus_done` pulses once per access.
- R11: The command and address latches are never high together, and the I/O driver is never on while the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request |
| bus_write | input | 1 | 1 for a write, 0 for a read (matters in the data phase) |
| bus_addr | input | ADDR_W | Access address that carries the encoded operation |
| bus_wdata | input | DATA_W | Address bytes or payload |
| bus_ready | output | 1 | High when a new access can be accepted |
| bus_done | output | 1 | One-cycle pulse when the access sequence ends |
| bus_rdata | output | DATA_W | Assembled read data, valid with `bus_done` |
| ecc_last | output | 1 | Error-code-final marker pulse |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | Byte driven onto the flash bus |
| nand_io_oe | output | 1 | Output enable for `nand_io_out` |
| nand_io_in | input | 8 | Byte returned by the flash |

## Verification
The bench drives command-phase accesses with address counts of 0, 3 and 5. These separate the opcode-only path, the single-access address path and the split path, where the second access must not repeat the opening opcode. Closing opcodes are flagged on some accesses and not on others, so an opcode leaking from a stale field shows up as an extra latch cycle. Data-phase writes and reads use distinct byte patterns, with the release and final-marker bits varied on their own. This tells byte-order errors, strobe direction errors and premature chip-enable release apart, and the strobe low widths are measured against the parameter.

// File: rtl/nand_dec_pkg.sv
package nand_dec_pkg;

    localparam int OPA_LSB   = 3;
    localparam int OPB_LSB   = 11;
    localparam int PHASE_BIT = 19;
    localparam int CLOSE_BIT = 20;
    localparam int CNT_LSB   = 21;
    localparam int REL_BIT   = 21;
    localparam int FINAL_BIT = 10;
    localparam int CNT_W     = 3;

    typedef enum logic [1:0] {
        BC_CMD  = 2'd0,
        BC_ADDR = 2'd1,
        BC_DWR  = 2'd2,
        BC_DRD  = 2'd3
    } bcyc_e;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_CMD  = 3'd1,
        S_ADDR = 3'd2,
        S_DATA = 3'd3,
        S_END  = 3'd4,
        S_FIN  = 3'd5
    } seq_e;

    typedef enum logic [1:0] {
        E_IDLE = 2'd0,
        E_LOW  = 2'd1,
        E_HIGH = 2'd2
    } eng_e;

    typedef struct packed {
        logic             data_ph;
        logic [7:0]       open_op;
        logic [7:0]       close_op;
        logic             close_ok;
        logic [CNT_W-1:0] acnt;
        logic             rel_cs;
        logic             fin_mark;
    } acc_t;

    function automatic acc_t decode_addr(input logic [23:3] a);
        acc_t d;
        d.data_ph  = a[PHASE_BIT];
        d.open_op  = a[OPA_LSB +: 8];
        d.close_op = a[OPB_LSB +: 8];
        d.close_ok = a[CLOSE_BIT];
        d.acnt     = a[CNT_LSB +: CNT_W];
        d.rel_cs   = a[REL_BIT];
        d.fin_mark = a[FINAL_BIT];
        return d;
    endfunction

endpackage

// File: rtl/nand_byte_engine.sv
module nand_byte_engine
    import nand_dec_pkg::*;
#(
    parameter int STROBE_CYC = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  bcyc_e      kind,
    input  logic [7:0] byte_in,
    input  logic [7:0] io_in,
    output logic       idle,
    output logic       done,
    output logic [7:0] rd_byte,
    output logic       cle,
    output logic       ale,
    output logic       we_n,
    output logic       re_n,
    output logic [7:0] io_out,
    output logic       io_oe
);
    localparam int CW = (STROBE_CYC < 2) ? 1 : $clog2(STROBE_CYC);

    eng_e        st;
    bcyc_e       kind_q;
    logic [CW-1:0] cnt;
    logic [7:0]  byte_q;
    logic [7:0]  rd_q;
    logic        active;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= E_IDLE;
            kind_q <= BC_CMD;
            cnt    <= '0;
            byte_q <= '0;
            rd_q   <= '0;
        end else begin
            case (st)
                E_IDLE: begin
                    if (start) begin
                        kind_q <= kind;
                        byte_q <= byte_in;
                        cnt    <= CW'(STROBE_CYC - 1);
                        st     <= E_LOW;
                    end
                end
                E_LOW: begin
                    if (cnt == '0) begin
                        if (kind_q == BC_DRD) rd_q <= io_in;
                        cnt <= CW'(STROBE_CYC - 1);
                        st  <= E_HIGH;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                E_HIGH: begin
                    if (cnt == '0) st <= E_IDLE;
                    else           cnt <= cnt - 1'b1;
                end
                default: st <= E_IDLE;
            endcase
        end
    end

    always_comb begin
        active  = (st != E_IDLE);
        idle    = !active;
        done    = (st == E_HIGH) && (cnt == '0);
        cle     = active && (kind_q == BC_CMD);
        ale     = active && (kind_q == BC_ADDR);
        we_n    = !((st == E_LOW) && (kind_q != BC_DRD));
        re_n    = !((st == E_LOW) && (kind_q == BC_DRD));
        io_oe   = active && (kind_q != BC_DRD);
        io_out  = io_oe ? byte_q : 8'h00;
        rd_byte = rd_q;
    end

endmodule

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
    import nand_dec_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_go,
    input  acc_t              acc,
    input  logic              is_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              eng_idle,
    input  logic              eng_done,
    input  logic [7:0]        eng_rd_byte,
    output logic              eng_start,
    output bcyc_e             eng_kind,
    output logic [7:0]        eng_byte,
    output logic              ready,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              fin_pulse,
    output logic              ce_act
);
    localparam int DBYTES = DATA_W / 8;
    localparam int IW     = $clog2(DBYTES + 1);

    seq_e              st;
    logic [DATA_W-1:0] wd_q;
    logic [DATA_W-1:0] rd_q;
    logic [7:0]        open_q;
    logic [7:0]        close_q;
    logic              close_now_q;
    logic              data_q;
    logic              wr_q;
    logic              rel_q;
    logic              fin_q;
    logic [IW-1:0]     n_now;
    logic [IW-1:0]     idx;
    logic              ce_q;

    logic              hold_pend;
    logic [CNT_W-1:0]  hold_rem;
    logic [7:0]        hold_op;
    logic              hold_ok;

    logic [CNT_W-1:0]  n_eff;
    logic [7:0]        op_eff;
    logic              ok_eff;
    logic [7:0]        sel_byte;

    always_comb begin
        if (hold_pend) begin
            n_eff  = hold_rem;
            op_eff = hold_op;
            ok_eff = hold_ok;
        end else begin
            n_eff  = acc.acnt;
            op_eff = acc.close_op;
            ok_eff = acc.close_ok;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= S_IDLE;
            wd_q        <= '0;
            rd_q        <= '0;
            open_q      <= '0;
            close_q     <= '0;
            close_now_q <= 1'b0;
            data_q      <= 1'b0;
            wr_q        <= 1'b0;
            rel_q       <= 1'b0;
            fin_q       <= 1'b0;
            n_now       <= '0;
            idx         <= '0;
            ce_q        <= 1'b0;
            hold_pend   <= 1'b0;
            hold_rem    <= '0;
            hold_op     <= '0;
            hold_ok     <= 1'b0;
        end else begin
            case (st)
                S_IDLE: begin
                    if (acc_go) begin
                        wd_q   <= wdata;
                        idx    <= '0;
                        ce_q   <= 1'b1;
                        data_q <= acc.data_ph;
                        wr_q   <= is_wr;
                        rel_q  <= acc.rel_cs;
                        fin_q  <= acc.fin_mark;
                        if (acc.data_ph) begin
                            close_q     <= acc.close_op;
                            close_now_q <= acc.close_ok;
                            st          <= S_DATA;
                        end else begin
                            open_q  <= acc.open_op;
                            close_q <= op_eff;
                            st      <= hold_pend ? S_ADDR : S_CMD;
                            if (int'(n_eff) > DBYTES) begin
                                n_now       <= IW'(DBYTES);
                                hold_pend   <= 1'b1;
                                hold_rem    <= CNT_W'(int'(n_eff) - DBYTES);
                                hold_op     <= op_eff;
                                hold_ok     <= ok_eff;
                                close_now_q <= 1'b0;
                            end else begin
                                n_now       <= IW'(n_eff);
                                hold_pend   <= 1'b0;
                                close_now_q <= ok_eff;
                            end
                        end
                    end
                end
                S_CMD: begin
                    if (eng_done) begin
                        if (n_now != '0)      st <= S_ADDR;
                        else if (close_now_q) st <= S_END;
                        else                  st <= S_FIN;
                    end
                end
                S_ADDR: begin
                    if (eng_done) begin
                        if (idx == n_now - 1'b1) begin
                            idx <= '0;
                            st  <= close_now_q ? S_END : S_FIN;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                S_DATA: begin
                    if (eng_done) begin
                        if (!wr_q) begin
                            for (int i = 0; i < DBYTES; i++) begin
                                if (idx == IW'(i)) rd_q[i*8 +: 8] <= eng_rd_byte;
                            end
                        end
                        if (idx == IW'(DBYTES - 1)) begin
                            idx <= '0;
                            st  <= close_now_q ? S_END : S_FIN;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                S_END: begin
                    if (eng_done) st <= S_FIN;
                end
                S_FIN: begin
                    st <= S_IDLE;
                    if (data_q && rel_q) ce_q <= 1'b0;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        sel_byte = 8'h00;
        for (int i = 0; i < DBYTES; i++) begin
            if (idx == IW'(i)) sel_byte = wd_q[i*8 +: 8];
        end
    end

    always_comb begin
        eng_start = eng_idle && (st == S_CMD || st == S_ADDR ||
                                 st == S_DATA || st == S_END);
        case (st)
            S_ADDR:  begin eng_kind = BC_ADDR; eng_byte = sel_byte; end
            S_DATA:  begin eng_kind = wr_q ? BC_DWR : BC_DRD; eng_byte = sel_byte; end
            S_END:   begin eng_kind = BC_CMD;  eng_byte = close_q; end
            default: begin eng_kind = BC_CMD;  eng_byte = open_q; end
        endcase
        ready     = (st == S_IDLE);
        done      = (st == S_FIN);
        fin_pulse = (st == S_FIN) && data_q && fin_q;
        rdata     = rd_q;
        ce_act    = ce_q;
    end

endmodule

// File: rtl/nand_cmd_decoder.sv
module nand_cmd_decoder
    import nand_dec_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int DATA_W     = 32,
    parameter int STROBE_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ready,
    output logic              bus_done,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              ecc_last,
    output logic              nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [7:0]        nand_io_out,
    output logic              nand_io_oe,
    input  logic [7:0]        nand_io_in
);
    acc_t       acc;
    logic       acc_go;
    logic       eng_start, eng_idle, eng_done;
    bcyc_e      eng_kind;
    logic [7:0] eng_byte, eng_rd_byte;
    logic       ce_act;
    logic       unused_addr_bits;

    assign acc              = decode_addr(bus_addr[23:3]);
    assign unused_addr_bits = ^bus_addr[2:0];
    assign acc_go           = bus_valid && bus_ready;
    assign nand_ce_n        = !ce_act;

    nand_seq_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .acc_go      (acc_go),
        .acc         (acc),
        .is_wr       (bus_write),
        .wdata       (bus_wdata),
        .eng_idle    (eng_idle),
        .eng_done    (eng_done),
        .eng_rd_byte (eng_rd_byte),
        .eng_start   (eng_start),
        .eng_kind    (eng_kind),
        .eng_byte    (eng_byte),
        .ready       (bus_ready),
        .done        (bus_done),
        .rdata       (bus_rdata),
        .fin_pulse   (ecc_last),
        .ce_act      (ce_act)
    );

    nand_byte_engine #(.STROBE_CYC(STROBE_CYC)) u_eng (
        .clk     (clk),
        .rst     (rst),
        .start   (eng_start),
        .kind    (eng_kind),
        .byte_in (eng_byte),
        .io_in   (nand_io_in),
        .idle    (eng_idle),
        .done    (eng_done),
        .rd_byte (eng_rd_byte),
        .cle     (nand_cle),
        .ale     (nand_ale),
        .we_n    (nand_we_n),
        .re_n    (nand_re_n),
        .io_out  (nand_io_out),
        .io_oe   (nand_io_oe)
    );

    logic [15:0] we_run;
    always_ff @(posedge clk) begin
        if (rst)             we_run <= '0;
        else if (!nand_we_n) we_run <= we_run + 1'b1;
        else                 we_run <= '0;
    end

    assert_latch_excl_R11: assert property (@(posedge clk) disable iff (rst)
        !(nand_cle && nand_ale));

    assert_io_dir_R11: assert property (@(posedge clk) disable iff (rst)
        !(nand_io_oe && !nand_re_n));

    assert_strobe_ce_R8: assert property (@(posedge clk) disable iff (rst)
        (!nand_we_n || !nand_re_n) |-> !nand_ce_n);

    assert_ce_release_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(nand_ce_n) |-> $past(bus_done));

    assert_busy_R10: assert property (@(posedge clk) disable iff (rst)
        (!nand_we_n || !nand_re_n) |-> !bus_ready);

    assert_we_width_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(nand_we_n) |-> (we_run == 16'(STROBE_CYC)));

    assert_final_done_R9: assert property (@(posedge clk) disable iff (rst)
        ecc_last |-> bus_done);

endmodule

// File: tb/nand_cmd_decoder_tb.sv
module nand_cmd_decoder_tb;
    localparam int STB = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [23:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready, bus_done, ecc_last;
    logic [31:0] bus_rdata;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
    logic [7:0]  nand_io_out;
    logic [7:0]  nand_io_in = 8'h00;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    nand_cmd_decoder #(.ADDR_W(24), .DATA_W(32), .STROBE_CYC(STB)) u_dut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_done(bus_done), .bus_rdata(bus_rdata), .ecc_last(ecc_last),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_io_out(nand_io_out),
        .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in)
    );

    logic [9:0] log_e [0:255];
    int log_n = 0;
    int rd_k = 0;
    int re_cnt = 0;
    int done_cnt = 0;
    int fin_cnt = 0;
    logic [31:0] last_rdata = '0;
    int w_run = 0, r_run = 0;
    int w_min = 999, w_max = 0, r_min = 999, r_max = 0;
    logic prev_we = 1'b1, prev_re = 1'b1;

    function automatic logic [7:0] rd_model(input int k);
        return 8'(8'hC3 ^ (k * 37));
    endfunction

    always @(negedge clk) begin
        if (!rst) begin
            if (!nand_we_n) w_run++;
            if (!nand_re_n) r_run++;
            if (!prev_we && nand_we_n) begin
                log_e[log_n[7:0]] = {nand_cle, nand_ale, nand_io_out};
                log_n++;
                if (w_run < w_min) w_min = w_run;
                if (w_run > w_max) w_max = w_run;
                w_run = 0;
            end
            if (prev_re && !nand_re_n) begin
                nand_io_in = rd_model(rd_k);
                rd_k++;
            end
            if (!prev_re && nand_re_n) begin
                re_cnt++;
                if (r_run < r_min) r_min = r_run;
                if (r_run > r_max) r_max = r_run;
                r_run = 0;
            end
            if (bus_done) begin
                done_cnt++;
                last_rdata = bus_rdata;
                if (ecc_last) fin_cnt++;
            end
            prev_we = nand_we_n;
            prev_re = nand_re_n;
        end
    end

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    function automatic logic [23:0] cmd_addr(input logic [7:0] op, input logic [7:0] cl,
                                              input logic clv, input logic [2:0] n);
        return {n, clv, 1'b0, cl, op, 3'b000};
    endfunction

    function automatic logic [23:0] dat_addr(input logic rel, input logic clv,
                                              input logic [7:0] cl, input logic fin);
        return {2'b00, rel, clv, 1'b1, cl, fin, 7'b0, 3'b000};
    endfunction

    task automatic access(input logic [23:0] a, input logic [31:0] wd, input logic wr);
        int base;
        base = done_cnt;
        @(negedge clk);
        while (!bus_ready) @(negedge clk);
        bus_addr = a; bus_wdata = wd; bus_write = wr; bus_valid = 1'b1;
        @(negedge clk);
        bus_valid = 1'b0;
        #1;
        chk("R10 ready low after accept", 32'(bus_ready), 32'd0);
        while (done_cnt == base) begin
            @(negedge clk);
            #1;
        end
        chk("R10 single done pulse", 32'(done_cnt - base), 32'd1);
        @(negedge clk);
        #1;
    endtask

    task automatic expect_log(input string req, input int base, input int n,
                              input logic [9:0] e0, input logic [9:0] e1, input logic [9:0] e2,
                              input logic [9:0] e3, input logic [9:0] e4);
        logic [9:0] ex [0:4];
        ex[0] = e0; ex[1] = e1; ex[2] = e2; ex[3] = e3; ex[4] = e4;
        chk({req, " cycle count"}, 32'(log_n - base), 32'(n));
        for (int i = 0; i < n && i < 5; i++)
            chk({req, " cycle"}, 32'(log_e[8'(base + i)]), 32'(ex[i]));
    endtask

    // R2 R3: opcode alone
    task automatic t_cmd_only();
        int b = log_n;
        access(cmd_addr(8'hFF, 8'h00, 1'b0, 3'd0), 32'h0, 1'b1);
        expect_log("R2 R3 opcode only", b, 1, {2'b10, 8'hFF}, 0, 0, 0, 0);
        chk("R8 ce low after command", 32'(nand_ce_n), 32'd0);
    endtask

    // R3 R4: three address bytes and closing opcode
    task automatic t_cmd_addr3();
        int b = log_n;
        access(cmd_addr(8'h60, 8'hD0, 1'b1, 3'd3), 32'hEE33_2211, 1'b1);
        expect_log("R3 R4 three bytes", b, 5, {2'b10, 8'h60}, {2'b01, 8'h11},
                   {2'b01, 8'h22}, {2'b01, 8'h33}, {2'b10, 8'hD0});
        chk("R8 bit21 as count keeps ce", 32'(nand_ce_n), 32'd0);
    endtask

    // R5: split across two accesses
    task automatic t_cmd_split();
        int b = log_n;
        access(cmd_addr(8'h00, 8'h30, 1'b1, 3'd5), 32'h4433_2211, 1'b1);
        expect_log("R5 first part", b, 5, {2'b10, 8'h00}, {2'b01, 8'h11},
                   {2'b01, 8'h22}, {2'b01, 8'h33}, {2'b01, 8'h44});
        b = log_n;
        access(cmd_addr(8'h00, 8'h00, 1'b0, 3'd0), 32'h0000_0055, 1'b1);
        expect_log("R5 second part", b, 2, {2'b01, 8'h55}, {2'b10, 8'h30}, 0, 0, 0);
        chk("R8 ce held across split", 32'(nand_ce_n), 32'd0);
    endtask

    // R6 R4: data write with closing opcode, no release, no marker
    task automatic t_data_write();
        int b = log_n;
        int f = fin_cnt;
        access(dat_addr(1'b0, 1'b1, 8'h10, 1'b0), 32'hA4A3_A2A1, 1'b1);
        expect_log("R6 R4 data write", b, 5, {2'b00, 8'hA1}, {2'b00, 8'hA2},
                   {2'b00, 8'hA3}, {2'b00, 8'hA4}, {2'b10, 8'h10});
        chk("R9 no marker without bit10", 32'(fin_cnt - f), 32'd0);
        chk("R8 ce kept without release", 32'(nand_ce_n), 32'd0);
    endtask

    // R7 R8 R9: data read with release and marker
    task automatic t_data_read();
        int b = log_n;
        int f = fin_cnt;
        int r = re_cnt;
        int k = rd_k;
        access(dat_addr(1'b1, 1'b0, 8'h00, 1'b1), 32'h0, 1'b0);
        chk("R7 read strobes", 32'(re_cnt - r), 32'd4);
        chk("R7 no write strobes in read", 32'(log_n - b), 32'd0);
        chk("R7 read data order", last_rdata,
            {rd_model(k + 3), rd_model(k + 2), rd_model(k + 1), rd_model(k)});
        chk("R9 marker with bit10", 32'(fin_cnt - f), 32'd1);
        chk("R8 ce released", 32'(nand_ce_n), 32'd1);
    endtask

    // R4 R8: read with no closing opcode and no release
    task automatic t_read_hold();
        int b = log_n;
        access(dat_addr(1'b0, 1'b0, 8'h77, 1'b0), 32'h0, 1'b0);
        chk("R4 no closing opcode when bit20 clear", 32'(log_n - b), 32'd0);
        chk("R8 ce low after read without release", 32'(nand_ce_n), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 ce_n", 32'(nand_ce_n), 32'd1);
        chk("R1 we_n re_n", {30'd0, nand_we_n, nand_re_n}, 32'd3);
        chk("R1 cle ale oe", {29'd0, nand_cle, nand_ale, nand_io_oe}, 32'd0);
        chk("R1 ready", 32'(bus_ready), 32'd1);
        t_cmd_only();
        t_cmd_addr3();
        t_cmd_split();
        t_data_write();
        t_data_read();
        t_read_hold();
        chk("R10 write strobe min width", 32'(w_min), 32'(STB));
        chk("R10 write strobe max width", 32'(w_max), 32'(STB));
        chk("R10 read strobe min width", 32'(r_min), 32'(STB));
        chk("R10 read strobe max width", 32'(r_max), 32'(STB));
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL R10 watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule